// File: doc/BRIEF.md
# Receive Acceptance Mask Bank

This block stores the acceptance masks that the identifier filter of a CAN receive path applies. It holds sixty-four 32-bit mask words. Software loads them through a simple word-indexed register port with byte-enable writes, and the matching engine fetches them through a separate read port.

Host access is gated by two inputs. A feature-enable input, when low, turns every host access into an error response. A freeze input, when low, silently drops writes and makes reads return zero. The error case is checked first, so it overrides the freeze gating.

The filter-side port names its target either as a message buffer or as a receive-FIFO filter element. A FIFO-enable input selects how targets are mapped onto mask words:
- With the FIFO off, buffer n uses word n, and FIFO element requests hit nothing.
- With the FIFO on, FIFO elements 0 to 7 use words 0 to 7. Buffers 8 and above keep their own word. Buffers 0 to 7 hit nothing, because those words now belong to the filter table.

The mask words are not cleared by reset.

Top module: `acc_mask_bank`

## Requirements
- R1: A host write while freeze and enable are both high updates only the bytes of word host_idx_i whose host_be_i bit is set (bit b covers data bits 8b+7 to 8b). It answers with host_done_o high for one cycle in the following cycle.
- R2: A host read while freeze and enable are both high returns the stored word on host_rdata_o with host_done_o high, one cycle after the request.
- R3: A host write while freeze is low (enable high) leaves the word unchanged and still answers with host_done_o.
- R4: A host read while freeze is low (enable high) answers with host_done_o and host_rdata_o equal to zero.
- R5: Any host request while enable is low answers with host_err_o high, host_done_o low and host_rdata_o zero, whatever the freeze input is. A write made this way changes nothing.
- R6: With fifo_en_i low, a filter request for buffer n (flt_fifo_sel_i=0) returns word n with flt_valid_o high one cycle later. A request for a FIFO element (flt_fifo_sel_i=1) returns flt_valid_o low and zero data.
- R7: With fifo_en_i high, FIFO element k for k<8 returns word k, and buffer n for n>=8 returns word n. Buffer n<8 and element k>=8 return flt_valid_o low and zero data. All results appear one cycle later.
- R8: The filter port answers the same way whatever the freeze and enable inputs are.
- R9: Reset clears every response output, but it leaves the stored mask words as they were.
- R10: In a cycle after one with no host request, host_done_o and host_err_o are both low. In a cycle after one with no filter request, flt_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the response registers |
| freeze_i | input | 1 | Freeze mode; host access is allowed only while high |
| mask_en_i | input | 1 | Mask feature enable; when low, host accesses produce an error |
| fifo_en_i | input | 1 | Receive FIFO enabled; selects the target mapping |
| host_req_i | input | 1 | Host access request strobe |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_idx_i | input | 6 | Mask word index |
| host_be_i | input | 4 | Byte enables for writes |
| host_wdata_i | input | 32 | Write data |
| host_done_o | output | 1 | Access completed (one cycle after the request) |
| host_err_o | output | 1 | Access error (one cycle after the request) |
| host_rdata_o | output | 32 | Read data |
| flt_req_i | input | 1 | Filter-side fetch request |
| flt_fifo_sel_i | input | 1 | 1 = FIFO filter element, 0 = message buffer |
| flt_idx_i | input | 6 | Buffer or element index |
| flt_valid_o | output | 1 | Target mapped to a mask word |
| flt_mask_o | output | 32 | Fetched mask, zero when not valid |

## Verification
The bench first checks that partial byte enables merge new bytes into the existing word. A design that wrote the whole word would lose the upper half.

It reads a word back in freeze after an attempted write outside freeze, and after an attempted write with the feature disabled. A design that did not gate writes, or that tested freeze before the enable, would show the new value or report done instead of the error.

The filter port is probed on both sides of the FIFO boundary at index 8, in both mapping modes. A design with a misplaced boundary or a wrong mode decode would return a mask for a word that belongs to the other kind of target.

Finally, reset is asserted after the masks are loaded. A design that cleared its storage on reset would then read back zero.

// File: rtl/amb_pkg.sv
package amb_pkg;

    typedef enum logic [2:0] {
        ACT_NONE  = 3'd0,
        ACT_ERR   = 3'd1,
        ACT_WRITE = 3'd2,
        ACT_DROP  = 3'd3,
        ACT_READ  = 3'd4,
        ACT_ZERO  = 3'd5
    } host_act_e;

    // Enable check first, freeze gating second.
    function automatic host_act_e amb_classify(
        input logic req,
        input logic we,
        input logic en,
        input logic frz
    );
        host_act_e a;
        if (!req)       a = ACT_NONE;
        else if (!en)   a = ACT_ERR;
        else if (we)    a = frz ? ACT_WRITE : ACT_DROP;
        else            a = frz ? ACT_READ  : ACT_ZERO;
        return a;
    endfunction

endpackage

// File: rtl/amb_store.sv
module amb_store #(
    parameter int DEPTH = 64,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH),
    localparam int NB   = DW / 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [NB-1:0] wr_be,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_a_idx,
    output logic [DW-1:0] rd_a_data,
    input  logic [IW-1:0] rd_b_idx,
    output logic [DW-1:0] rd_b_data
);
    // Storage carries no reset; unwritten words stay unknown in 4-state simulation.
    logic [DW-1:0] words [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
        for (genvar gb = 0; gb < NB; gb++) begin : g_byte
            always_ff @(posedge clk) begin
                if (wr_en && (wr_idx == IW'(gi)) && wr_be[gb])
                    words[gi][gb*8 +: 8] <= wr_data[gb*8 +: 8];
            end
        end
    end

    assign rd_a_data = words[rd_a_idx];
    assign rd_b_data = words[rd_b_idx];
endmodule

// File: rtl/amb_host_gate.sv
module amb_host_gate #(
    parameter int DEPTH = 64,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH),
    localparam int NB   = DW / 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          freeze,
    input  logic          enable,
    input  logic          req,
    input  logic          we,
    input  logic [DW-1:0] word_in,
    output logic          store_wr,
    output logic          done,
    output logic          err,
    output logic [DW-1:0] rdata
);
    import amb_pkg::*;

    host_act_e act;

    always_comb begin
        act      = amb_classify(req, we, enable, freeze);
        store_wr = (act == ACT_WRITE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done  <= 1'b0;
            err   <= 1'b0;
            rdata <= '0;
        end else begin
            done  <= (act == ACT_WRITE) || (act == ACT_DROP) ||
                     (act == ACT_READ)  || (act == ACT_ZERO);
            err   <= (act == ACT_ERR);
            rdata <= (act == ACT_READ) ? word_in : '0;
        end
    end
endmodule

// File: rtl/amb_target_map.sv
module amb_target_map #(
    parameter int DEPTH      = 64,
    parameter int FIFO_ELEMS = 8,
    localparam int IW        = $clog2(DEPTH)
) (
    input  logic          fifo_en,
    input  logic          sel_fifo,
    input  logic [IW-1:0] idx,
    output logic          hit,
    output logic [IW-1:0] word_idx
);
    logic in_table;

    always_comb begin
        in_table = (idx < IW'(FIFO_ELEMS));
        word_idx = idx;
        if (sel_fifo)
            hit = fifo_en && in_table;
        else
            hit = !(fifo_en && in_table);
    end
endmodule

// File: rtl/acc_mask_bank.sv
module acc_mask_bank #(
    parameter int DEPTH      = 64,
    parameter int DW         = 32,
    parameter int FIFO_ELEMS = 8,
    localparam int IW        = $clog2(DEPTH),
    localparam int NB        = DW / 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          freeze_i,
    input  logic          mask_en_i,
    input  logic          fifo_en_i,
    input  logic          host_req_i,
    input  logic          host_we_i,
    input  logic [IW-1:0] host_idx_i,
    input  logic [NB-1:0] host_be_i,
    input  logic [DW-1:0] host_wdata_i,
    output logic          host_done_o,
    output logic          host_err_o,
    output logic [DW-1:0] host_rdata_o,
    input  logic          flt_req_i,
    input  logic          flt_fifo_sel_i,
    input  logic [IW-1:0] flt_idx_i,
    output logic          flt_valid_o,
    output logic [DW-1:0] flt_mask_o
);
    logic          store_wr;
    logic [DW-1:0] host_word;
    logic [DW-1:0] flt_word;
    logic          map_hit;
    logic [IW-1:0] map_idx;

    amb_host_gate #(.DEPTH(DEPTH), .DW(DW)) u_gate (
        .clk     (clk),
        .rst     (rst),
        .freeze  (freeze_i),
        .enable  (mask_en_i),
        .req     (host_req_i),
        .we      (host_we_i),
        .word_in (host_word),
        .store_wr(store_wr),
        .done    (host_done_o),
        .err     (host_err_o),
        .rdata   (host_rdata_o)
    );

    amb_target_map #(.DEPTH(DEPTH), .FIFO_ELEMS(FIFO_ELEMS)) u_map (
        .fifo_en (fifo_en_i),
        .sel_fifo(flt_fifo_sel_i),
        .idx     (flt_idx_i),
        .hit     (map_hit),
        .word_idx(map_idx)
    );

    amb_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk      (clk),
        .wr_en    (store_wr),
        .wr_idx   (host_idx_i),
        .wr_be    (host_be_i),
        .wr_data  (host_wdata_i),
        .rd_a_idx (host_idx_i),
        .rd_a_data(host_word),
        .rd_b_idx (map_idx),
        .rd_b_data(flt_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flt_valid_o <= 1'b0;
            flt_mask_o  <= '0;
        end else begin
            flt_valid_o <= flt_req_i && map_hit;
            flt_mask_o  <= (flt_req_i && map_hit) ? flt_word : '0;
        end
    end
endmodule

// File: rtl/amb_checker.sv
module amb_checker #(
    parameter int DW         = 32,
    parameter int IW         = 6,
    parameter int FIFO_ELEMS = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          freeze_i,
    input logic          mask_en_i,
    input logic          fifo_en_i,
    input logic          host_req_i,
    input logic          host_we_i,
    input logic          host_done_o,
    input logic          host_err_o,
    input logic [DW-1:0] host_rdata_o,
    input logic          flt_req_i,
    input logic          flt_fifo_sel_i,
    input logic [IW-1:0] flt_idx_i,
    input logic          flt_valid_o,
    input logic [DW-1:0] flt_mask_o
);
    assert_done_err_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        !(host_done_o && host_err_o));

    assert_disabled_errors_R5: assert property (@(posedge clk) disable iff (rst)
        (host_req_i && !mask_en_i) |=> (host_err_o && !host_done_o && host_rdata_o == '0));

    assert_unfrozen_read_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (host_req_i && !host_we_i && mask_en_i && !freeze_i) |=> (host_done_o && host_rdata_o == '0));

    assert_unfrozen_write_done_R3: assert property (@(posedge clk) disable iff (rst)
        (host_req_i && host_we_i && mask_en_i && !freeze_i) |=> (host_done_o && !host_err_o));

    assert_idle_host_R10: assert property (@(posedge clk) disable iff (rst)
        !host_req_i |=> (!host_done_o && !host_err_o));

    assert_idle_filter_R10: assert property (@(posedge clk) disable iff (rst)
        !flt_req_i |=> (!flt_valid_o && flt_mask_o == '0));

    assert_buffer_fifo_off_R6: assert property (@(posedge clk) disable iff (rst)
        (flt_req_i && !fifo_en_i && !flt_fifo_sel_i) |=> flt_valid_o);

    assert_element_fifo_off_R6: assert property (@(posedge clk) disable iff (rst)
        (flt_req_i && !fifo_en_i && flt_fifo_sel_i) |=> (!flt_valid_o && flt_mask_o == '0));

    assert_low_buffer_fifo_on_R7: assert property (@(posedge clk) disable iff (rst)
        (flt_req_i && fifo_en_i && !flt_fifo_sel_i && flt_idx_i < IW'(FIFO_ELEMS))
        |=> (!flt_valid_o && flt_mask_o == '0));

    assert_table_elem_fifo_on_R7: assert property (@(posedge clk) disable iff (rst)
        (flt_req_i && fifo_en_i && flt_fifo_sel_i && flt_idx_i < IW'(FIFO_ELEMS)) |=> flt_valid_o);
endmodule

bind acc_mask_bank amb_checker #(.DW(DW), .IW(IW), .FIFO_ELEMS(FIFO_ELEMS)) u_amb_checker (
    .clk           (clk),
    .rst           (rst),
    .freeze_i      (freeze_i),
    .mask_en_i     (mask_en_i),
    .fifo_en_i     (fifo_en_i),
    .host_req_i    (host_req_i),
    .host_we_i     (host_we_i),
    .host_done_o   (host_done_o),
    .host_err_o    (host_err_o),
    .host_rdata_o  (host_rdata_o),
    .flt_req_i     (flt_req_i),
    .flt_fifo_sel_i(flt_fifo_sel_i),
    .flt_idx_i     (flt_idx_i),
    .flt_valid_o   (flt_valid_o),
    .flt_mask_o    (flt_mask_o)
);

// File: tb/acc_mask_bank_bench.sv
module acc_mask_bank_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        freeze_i, mask_en_i, fifo_en_i;
    logic        host_req_i, host_we_i;
    logic [5:0]  host_idx_i;
    logic [3:0]  host_be_i;
    logic [31:0] host_wdata_i;
    logic        host_done_o, host_err_o;
    logic [31:0] host_rdata_o;
    logic        flt_req_i, flt_fifo_sel_i;
    logic [5:0]  flt_idx_i;
    logic        flt_valid_o;
    logic [31:0] flt_mask_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5ns clk = ~clk;

    acc_mask_bank u_acc_mask_bank (
        .clk(clk), .rst(rst), .freeze_i(freeze_i), .mask_en_i(mask_en_i),
        .fifo_en_i(fifo_en_i), .host_req_i(host_req_i), .host_we_i(host_we_i),
        .host_idx_i(host_idx_i), .host_be_i(host_be_i), .host_wdata_i(host_wdata_i),
        .host_done_o(host_done_o), .host_err_o(host_err_o), .host_rdata_o(host_rdata_o),
        .flt_req_i(flt_req_i), .flt_fifo_sel_i(flt_fifo_sel_i), .flt_idx_i(flt_idx_i),
        .flt_valid_o(flt_valid_o), .flt_mask_o(flt_mask_o)
    );

    typedef struct packed {
        logic        we;
        logic        frz;
        logic        en;
        logic [5:0]  idx;
        logic [3:0]  be;
        logic [31:0] wd;
        logic        x_done;
        logic        x_err;
        logic [31:0] x_rd;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 1'b1, 6'd5,  4'hF, 32'hA5A5_1234, 1'b1, 1'b0, 32'h0},           // R1
        '{1'b0, 1'b1, 1'b1, 6'd5,  4'h0, 32'h0,         1'b1, 1'b0, 32'hA5A5_1234},   // R2
        '{1'b1, 1'b1, 1'b1, 6'd5,  4'h3, 32'hFFFF_0000, 1'b1, 1'b0, 32'h0},           // R1 partial
        '{1'b0, 1'b1, 1'b1, 6'd5,  4'h0, 32'h0,         1'b1, 1'b0, 32'hA5A5_0000},   // R1
        '{1'b1, 1'b0, 1'b1, 6'd5,  4'hF, 32'h0,         1'b1, 1'b0, 32'h0},           // R3
        '{1'b0, 1'b0, 1'b1, 6'd5,  4'h0, 32'h0,         1'b1, 1'b0, 32'h0},           // R4
        '{1'b0, 1'b1, 1'b1, 6'd5,  4'h0, 32'h0,         1'b1, 1'b0, 32'hA5A5_0000},   // R3
        '{1'b1, 1'b1, 1'b0, 6'd5,  4'hF, 32'h0,         1'b0, 1'b1, 32'h0},           // R5
        '{1'b0, 1'b0, 1'b0, 6'd5,  4'h0, 32'h0,         1'b0, 1'b1, 32'h0},           // R5
        '{1'b0, 1'b1, 1'b1, 6'd5,  4'h0, 32'h0,         1'b1, 1'b0, 32'hA5A5_0000},   // R5
        '{1'b1, 1'b1, 1'b1, 6'd63, 4'hF, 32'h0BAD_F00D, 1'b1, 1'b0, 32'h0},           // R1
        '{1'b0, 1'b1, 1'b1, 6'd63, 4'h0, 32'h0,         1'b1, 1'b0, 32'h0BAD_F00D},   // R2
        '{1'b1, 1'b1, 1'b1, 6'd0,  4'hC, 32'h1111_2222, 1'b1, 1'b0, 32'h0},           // R1
        '{1'b0, 1'b1, 1'b0, 6'd0,  4'h0, 32'h0,         1'b0, 1'b1, 32'h0}            // R5
    };

    function automatic logic [31:0] mval(int i);
        return 32'hC0DE_0000 | (i * 32'h111);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_op(input logic we, input logic frz, input logic en, input logic [5:0] idx,
                           input logic [3:0] be, input logic [31:0] wd);
        @(negedge clk);
        host_req_i = 1'b1; host_we_i = we; freeze_i = frz; mask_en_i = en;
        host_idx_i = idx; host_be_i = be; host_wdata_i = wd;
        @(negedge clk);
        host_req_i = 1'b0;
    endtask

    task automatic flt_op(input logic fe, input logic sel, input logic [5:0] idx,
                          input logic x_v, input logic [31:0] x_m, input string tag);
        @(negedge clk);
        flt_req_i = 1'b1; fifo_en_i = fe; flt_fifo_sel_i = sel; flt_idx_i = idx;
        @(negedge clk);
        flt_req_i = 1'b0;
        check(flt_valid_o === x_v, {tag, " valid"}, 32'(flt_valid_o), 32'(x_v));
        check(flt_mask_o === x_m, {tag, " mask"}, flt_mask_o, x_m);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        summary();
    end

    initial begin
        rst = 1'b1; freeze_i = 1'b0; mask_en_i = 1'b1; fifo_en_i = 1'b0;
        host_req_i = 1'b0; host_we_i = 1'b0; host_idx_i = '0; host_be_i = '0; host_wdata_i = '0;
        flt_req_i = 1'b0; flt_fifo_sel_i = 1'b0; flt_idx_i = '0;
        repeat (3) @(negedge clk);
        check(!host_done_o && !host_err_o && host_rdata_o == 0, "R9 reset host outputs", host_rdata_o, 32'h0);
        check(!flt_valid_o && flt_mask_o == 0, "R9 reset filter outputs", flt_mask_o, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            host_op(VECS[i].we, VECS[i].frz, VECS[i].en, VECS[i].idx, VECS[i].be, VECS[i].wd);
            check(host_done_o === VECS[i].x_done, $sformatf("R1-R5 vector %0d done", i),
                  32'(host_done_o), 32'(VECS[i].x_done));
            check(host_err_o === VECS[i].x_err, $sformatf("R5 vector %0d err", i),
                  32'(host_err_o), 32'(VECS[i].x_err));
            check(host_rdata_o === VECS[i].x_rd, $sformatf("R2 vector %0d rdata", i),
                  host_rdata_o, VECS[i].x_rd);
        end

        // R1 upper bytes only on word 0
        host_op(1'b0, 1'b1, 1'b1, 6'd0, 4'h0, 32'h0);
        check(host_rdata_o[31:16] === 16'h1111, "R1 upper byte enables", host_rdata_o, 32'h1111_0000);

        // R10 idle cycle
        @(negedge clk);
        check(!host_done_o && !host_err_o, "R10 idle host", {30'b0, host_done_o, host_err_o}, 32'h0);
        check(!flt_valid_o, "R10 idle filter", 32'(flt_valid_o), 32'h0);

        // load masks 0..15
        for (int i = 0; i < 16; i++) host_op(1'b1, 1'b1, 1'b1, 6'(i), 4'hF, mval(i));

        // R6 FIFO off
        flt_op(1'b0, 1'b0, 6'd3, 1'b1, mval(3), "R6 buffer 3");
        flt_op(1'b0, 1'b0, 6'd9, 1'b1, mval(9), "R6 buffer 9");
        flt_op(1'b0, 1'b1, 6'd3, 1'b0, 32'h0, "R6 element while off");

        // R7 FIFO on
        flt_op(1'b1, 1'b1, 6'd2, 1'b1, mval(2), "R7 element 2");
        flt_op(1'b1, 1'b1, 6'd7, 1'b1, mval(7), "R7 element 7");
        flt_op(1'b1, 1'b0, 6'd8, 1'b1, mval(8), "R7 buffer 8");
        flt_op(1'b1, 1'b0, 6'd4, 1'b0, 32'h0, "R7 buffer 4 hidden");
        flt_op(1'b1, 1'b0, 6'd7, 1'b0, 32'h0, "R7 buffer 7 hidden");
        flt_op(1'b1, 1'b1, 6'd8, 1'b0, 32'h0, "R7 element 8 absent");

        // R8 independence from freeze and enable
        @(negedge clk);
        freeze_i = 1'b0; mask_en_i = 1'b0;
        flt_op(1'b1, 1'b0, 6'd12, 1'b1, mval(12), "R8 buffer 12 gated host");
        flt_op(1'b0, 1'b0, 6'd1, 1'b1, mval(1), "R8 buffer 1 gated host");

        // R9 storage survives reset
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(!host_done_o && !host_err_o && !flt_valid_o, "R9 outputs cleared",
              {29'b0, host_done_o, host_err_o, flt_valid_o}, 32'h0);
        rst = 1'b0;
        host_op(1'b0, 1'b1, 1'b1, 6'd9, 4'h0, 32'h0);
        check(host_rdata_o === mval(9), "R9 mask kept through reset", host_rdata_o, mval(9));

        summary();
    end
endmodule